// File: doc/BRIEF.md
# Rotate-Through-Carry Count Sequencer

This block performs rotate-through-carry in both directions on an 8-, 16- or 32-bit operand. The operand and the carry flag together form a ring of width+1 bits: 9, 17 or 33. The block is a small multi-cycle controller wrapped around a purely combinational funnel shifter. The shifter always rotates to the right. A left rotation by `c` is issued as a right rotation by `width+1-c`.

The count is masked to five bits, so it can exceed the operand width. The block does not divide by width+1. While the count is larger than the width, it takes the width off the count and rotates the ring one position against the requested direction; each such pass costs one cycle. When the count is no longer larger than the width, one final rotation by the remaining count finishes the job.

A caller pulses `start` with the operand, width code, direction, carry and count. It then waits for the one-cycle `done` pulse, when `res` and `cout` hold the result. Both stay unchanged until the next accepted start.

Top module: `rotc_seq`

## Requirements
- R1: With `rcl`=0 (right) or `rcl`=1 (left), `res` equals the width-bit operand after rotating the ring {carry, operand} by the masked count modulo width+1. The width codes are `wsel`=00 for 8 bits, 01 for 16 bits, and 10 or 11 for 32 bits.
- R2: Only bits 4:0 of `cnt_in` select the count; bits 7:5 have no effect on the result.
- R3: `cout` is the ring bit that lands in the carry position after the rotation.
- R4: A masked count of zero returns the operand (trimmed to the width) and the input carry unchanged.
- R5: When the masked count is no larger than the width, `done` is high in the cycle after the 9th rising edge that follows the edge accepting `start`.
- R6: When the masked count c exceeds the width w, the latency grows by (c-1)/w cycles (integer division), one per reduction pass.
- R7: `start` is accepted only while `busy` is low. `busy` stays high from the accepting edge through the `done` cycle, and a `start` seen while busy changes neither the result nor the timing.
- R8: `done` is high for exactly one cycle, and `res` and `cout` hold their values until the next accepted start.
- R9: Bits of `res` above the selected width are zero, whatever the operand's upper bits were.
- R10: During and right after reset, `busy`, `done`, `res` and `cout` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, sampled while idle |
| rcl | input | 1 | Direction: 1 rotates left, 0 rotates right |
| wsel | input | 2 | Width code: 00 byte, 01 halfword, 1x word |
| opnd | input | 32 | Operand; bits above the width are ignored |
| cin | input | 1 | Carry flag entering the ring |
| cnt_in | input | 8 | Rotate count; low five bits used |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| res | output | 32 | Rotated operand, zero-extended |
| cout | output | 1 | Carry flag after rotation |

## Verification
The bench sweeps every masked count from 0 to 31 in both directions for all three widths, using several operand patterns and both carry values. This covers counts equal to the width, one above it, and multiples of it. A design that subtracted width+1, or dropped the compensating one-step rotation, would return results off by one or more positions only on the reduction path. A design that counted passes wrongly would miss the latency checks. Counts with garbage in bits 7:5, and operands with garbage above the width, expose missing masks. A `start` pulsed mid-operation and another during the `done` cycle would corrupt the result or restart the sequencer if acceptance were not tied to idle.

// File: rtl/rcs_pkg.sv
`timescale 1ns/1ps
package rcs_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_PREP,
      S_LOOP,
      S_FIN,
      S_DONE
   } seq_state_t;

   // Operand width selected by the two-bit code, relative to the widest width.
   function automatic int width_of(input logic [1:0] code, input int max_w);
      case (code)
         2'b00:   return max_w / 4;
         2'b01:   return max_w / 2;
         default: return max_w;
      endcase
   endfunction

endpackage

// File: rtl/rcs_funnel.sv
`timescale 1ns/1ps
// Combinational right funnel: dout = vec >> amt, low MAX_W+1 bits.
module rcs_funnel #(
   parameter int MAX_W  = 32,
   parameter int FINE_W = 2,
   localparam int AW    = $clog2(MAX_W) + 1,
   localparam int VW    = 2 * MAX_W + 2
) (
   input  logic [VW-1:0]  vec,
   input  logic [AW-1:0]  amt,
   output logic [MAX_W:0] dout
);
   localparam int CS  = 1 << FINE_W;          // coarse step
   localparam int NCO = MAX_W / CS + 1;       // coarse positions
   localparam int S1W = MAX_W + CS;           // coarse stage output width
   localparam int PW  = S1W + NCO * CS;       // padded input width
   localparam int XW  = $clog2(PW);
   localparam int CW  = AW - FINE_W;

   logic [PW-1:0]  vpad;
   logic [CW-1:0]  crs;
   logic [S1W-1:0] c1;

   assign vpad = {{(PW - VW){1'b0}}, vec};
   assign crs  = amt[AW-1:FINE_W];

   // Coarse stage: crossbar over multiples of the coarse step.
   for (genvar i = 0; i < S1W; i++) begin : g_crs
      logic bsel;
      always_comb begin
         bsel = 1'b0;
         for (int k = 0; k < NCO; k++) begin
            if (crs == CW'(k)) bsel = vpad[XW'(i) + XW'(k * CS)];
         end
      end
      assign c1[i] = bsel;
   end

   if (FINE_W == 0) begin : g_flat
      assign dout = c1[MAX_W:0];
   end else begin : g_two
      localparam int FW = $clog2(S1W);
      logic [FINE_W-1:0] fin;
      assign fin = amt[FINE_W-1:0];
      // Fine stage: residual shift below one coarse step.
      for (genvar j = 0; j <= MAX_W; j++) begin : g_fin
         assign dout[j] = c1[FW'(j) + FW'(fin)];
      end
   end

endmodule

// File: rtl/rcs_rot_step.sv
`timescale 1ns/1ps
// One right rotation of the (w+1)-bit ring {carry, operand} by amt (1..w).
module rcs_rot_step #(
   parameter int MAX_W  = 32,
   parameter int FINE_W = 2,
   localparam int AW    = $clog2(MAX_W) + 1,
   localparam int VW    = 2 * MAX_W + 2
) (
   input  logic [AW-1:0]    wv,
   input  logic [MAX_W-1:0] x_in,
   input  logic             c_in,
   input  logic [AW-1:0]    amt,
   output logic [MAX_W-1:0] x_out,
   output logic             c_out
);
   logic [MAX_W:0] vmask;
   logic [MAX_W:0] ring;
   logic [MAX_W:0] rot;
   logic [VW-1:0]  vec;

   // Two back-to-back copies of the ring make a right shift act as a rotation.
   always_comb begin
      vmask = ~({(MAX_W + 1){1'b1}} << wv);
      ring  = ({1'b0, x_in} & vmask) | ((MAX_W + 1)'(c_in) << wv);
      vec   = VW'(ring) | (VW'(ring) << (wv + AW'(1)));
   end

   rcs_funnel #(
      .MAX_W (MAX_W),
      .FINE_W(FINE_W)
   ) i_funnel (
      .vec (vec),
      .amt (amt),
      .dout(rot)
   );

   assign x_out = rot[MAX_W-1:0] & ~({MAX_W{1'b1}} << wv);
   assign c_out = rot[wv];

endmodule

// File: rtl/rcs_fsm.sv
`timescale 1ns/1ps
module rcs_fsm
   import rcs_pkg::*;
#(
   parameter int MAX_W  = 32,
   parameter int LAT    = 9,
   localparam int CNT_W = $clog2(MAX_W),
   localparam int AW    = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             rcl,
   input  logic [1:0]       wsel,
   input  logic [MAX_W-1:0] opnd,
   input  logic             cin,
   input  logic [CNT_W-1:0] cnt,
   input  logic [MAX_W-1:0] step_x,
   input  logic             step_c,
   output logic [AW-1:0]    step_wv,
   output logic [MAX_W-1:0] step_xin,
   output logic             step_cin,
   output logic [AW-1:0]    step_amt,
   output logic             busy,
   output logic             done,
   output logic [MAX_W-1:0] res,
   output logic             cout
);
   localparam int PAD = LAT - 2;
   localparam int PCW = (PAD > 1) ? $clog2(PAD) : 1;

   seq_state_t       st_q;
   logic [MAX_W-1:0] x_q;
   logic             cf_q;
   logic [CNT_W-1:0] cnt_q;
   logic [AW-1:0]    wv_q;
   logic [AW-1:0]    wv_in;
   logic             dir_q;
   logic [PCW-1:0]   pad_q;
   logic             over;

   assign wv_in = AW'(width_of(wsel, MAX_W));
   assign over  = {1'b0, cnt_q} > wv_q;

   // Reduction pass: against the direction by one; final: by the residual count.
   always_comb begin
      if (st_q == S_LOOP) begin
         step_amt = dir_q ? AW'(1) : wv_q;
      end else begin
         step_amt = dir_q ? (wv_q + AW'(1) - {1'b0, cnt_q}) : {1'b0, cnt_q};
      end
   end

   assign step_wv  = wv_q;
   assign step_xin = x_q;
   assign step_cin = cf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= S_IDLE;
         x_q   <= '0;
         cf_q  <= 1'b0;
         cnt_q <= '0;
         wv_q  <= '0;
         dir_q <= 1'b0;
         pad_q <= '0;
      end else begin
         case (st_q)
            S_IDLE: begin
               if (start) begin
                  x_q   <= opnd & ~({MAX_W{1'b1}} << wv_in);
                  cf_q  <= cin;
                  cnt_q <= cnt;
                  wv_q  <= wv_in;
                  dir_q <= rcl;
                  pad_q <= PCW'(PAD - 1);
                  st_q  <= S_PREP;
               end
            end
            S_PREP: begin
               if (pad_q == '0) st_q <= S_LOOP;
               else             pad_q <= pad_q - PCW'(1);
            end
            S_LOOP: begin
               if (over) begin
                  x_q   <= step_x;
                  cf_q  <= step_c;
                  cnt_q <= cnt_q - CNT_W'(wv_q);
               end else begin
                  st_q <= S_FIN;
               end
            end
            S_FIN: begin
               if (cnt_q != '0) begin
                  x_q  <= step_x;
                  cf_q <= step_c;
               end
               st_q <= S_DONE;
            end
            S_DONE:  st_q <= S_IDLE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign busy = (st_q != S_IDLE);
   assign done = (st_q == S_DONE);
   assign res  = x_q;
   assign cout = cf_q;

endmodule

// File: rtl/rotc_seq.sv
`timescale 1ns/1ps
module rotc_seq #(
   parameter int MAX_W    = 32,
   parameter int CNT_IN_W = 8,
   parameter int FINE_W   = 2,
   parameter int LAT      = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                rcl,
   input  logic [1:0]          wsel,
   input  logic [MAX_W-1:0]    opnd,
   input  logic                cin,
   input  logic [CNT_IN_W-1:0] cnt_in,
   output logic                busy,
   output logic                done,
   output logic [MAX_W-1:0]    res,
   output logic                cout
);
   localparam int CNT_W = $clog2(MAX_W);
   localparam int AW    = CNT_W + 1;

   if (MAX_W < 8 || (1 << CNT_W) != MAX_W) begin : g_bad_width
      $error("MAX_W must be a power of two no smaller than 8");
   end
   if (CNT_IN_W <= CNT_W) begin : g_bad_cnt
      $error("CNT_IN_W must exceed the masked count width");
   end
   if (LAT < 3) begin : g_bad_lat
      $error("LAT must be at least 3");
   end
   if (FINE_W < 0 || (1 << FINE_W) > MAX_W) begin : g_bad_fine
      $error("FINE_W out of range");
   end

   logic [AW-1:0]    step_wv;
   logic [AW-1:0]    step_amt;
   logic [MAX_W-1:0] step_xin;
   logic [MAX_W-1:0] step_x;
   logic             step_cin;
   logic             step_c;
   logic             cnt_hi_unused;

   assign cnt_hi_unused = ^cnt_in[CNT_IN_W-1:CNT_W];

   rcs_fsm #(
      .MAX_W(MAX_W),
      .LAT  (LAT)
   ) i_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .rcl     (rcl),
      .wsel    (wsel),
      .opnd    (opnd),
      .cin     (cin),
      .cnt     (cnt_in[CNT_W-1:0]),
      .step_x  (step_x),
      .step_c  (step_c),
      .step_wv (step_wv),
      .step_xin(step_xin),
      .step_cin(step_cin),
      .step_amt(step_amt),
      .busy    (busy),
      .done    (done),
      .res     (res),
      .cout    (cout)
   );

   rcs_rot_step #(
      .MAX_W (MAX_W),
      .FINE_W(FINE_W)
   ) i_step (
      .wv   (step_wv),
      .x_in (step_xin),
      .c_in (step_cin),
      .amt  (step_amt),
      .x_out(step_x),
      .c_out(step_c)
   );

endmodule

// File: rtl/rotc_seq_chk.sv
`timescale 1ns/1ps
module rotc_seq_chk
   import rcs_pkg::*;
#(
   parameter int MAX_W  = 32,
   parameter int LAT    = 9,
   localparam int CNT_W = $clog2(MAX_W)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             cin,
   input logic [1:0]       wsel,
   input logic [MAX_W-1:0] opnd,
   input logic [CNT_W-1:0] cnt_lo,
   input logic             busy,
   input logic             done,
   input logic             cout,
   input logic [MAX_W-1:0] res
);
   localparam int MAXK = ((1 << CNT_W) - 2) / (MAX_W / 4);

   logic             acc;
   logic [7:0]       lat_q;
   logic             z_q;
   logic             c_q;
   logic [MAX_W-1:0] op_q;
   logic [MAX_W-1:0] wm_q;
   logic [MAX_W-1:0] wm_in;

   assign acc   = start && !busy;
   assign wm_in = ~({MAX_W{1'b1}} << width_of(wsel, MAX_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
         z_q   <= 1'b0;
         c_q   <= 1'b0;
         op_q  <= '0;
         wm_q  <= '0;
      end else if (acc) begin
         lat_q <= '0;
         z_q   <= (cnt_lo == '0);
         c_q   <= cin;
         op_q  <= opnd & wm_in;
         wm_q  <= wm_in;
      end else if (busy && lat_q != 8'hFF) begin
         lat_q <= lat_q + 8'd1;
      end
   end

   p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> busy);
   p_stay_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(res) && $stable(cout)));
   p_min_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(lat_q) >= LAT));
   p_max_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(lat_q) <= LAT + MAXK));
   p_zero_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && z_q) |-> (res == op_q && cout == c_q));
   p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((res & ~wm_q) == '0));

endmodule

bind rotc_seq rotc_seq_chk #(
   .MAX_W(MAX_W),
   .LAT  (LAT)
) i_rotc_seq_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .cin   (cin),
   .wsel  (wsel),
   .opnd  (opnd),
   .cnt_lo(cnt_in[$clog2(MAX_W)-1:0]),
   .busy  (busy),
   .done  (done),
   .cout  (cout),
   .res   (res)
);

// File: tb/test_rotc_seq.sv
`timescale 1ns/1ps
module test_rotc_seq;
   localparam int LAT = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        rcl = 1'b0;
   logic        cin = 1'b0;
   logic [1:0]  wsel = 2'b00;
   logic [31:0] opnd = '0;
   logic [7:0]  cnt_in = '0;
   logic        busy;
   logic        done;
   logic        cout;
   logic [31:0] res;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   rotc_seq i_rotc_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .rcl   (rcl),
      .wsel  (wsel),
      .opnd  (opnd),
      .cin   (cin),
      .cnt_in(cnt_in),
      .busy  (busy),
      .done  (done),
      .res   (res),
      .cout  (cout)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic int wid(input logic [1:0] code);
      if (code == 2'b00) return 8;
      if (code == 2'b01) return 16;
      return 32;
   endfunction

   // Bit-serial rotation of the (w+1)-bit ring, count reduced modulo w+1.
   task automatic ref_rot(input bit dir, input int w, input logic [31:0] x, input bit c,
                          input int cnt, output logic [31:0] xo, output bit co);
      logic [31:0] m;
      bit nc;
      m  = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
      xo = x & m;
      co = c;
      for (int s = 0; s < cnt % (w + 1); s++) begin
         if (dir) begin
            nc = xo[w-1];
            xo = ((xo << 1) | 32'(co)) & m;
         end else begin
            nc = xo[0];
            xo = (xo >> 1) | (32'(co) << (w - 1));
         end
         co = nc;
      end
   endtask

   task automatic run_op(input bit dir, input logic [1:0] ws, input logic [31:0] x,
                         input bit c, input logic [7:0] cn);
      int w, cm, k, n;
      logic [31:0] ex;
      bit ec;
      string tg;
      w  = wid(ws);
      cm = int'(cn[4:0]);
      k  = (cm > w) ? (cm - 1) / w : 0;
      ref_rot(dir, w, x, c, cm, ex, ec);
      @(negedge clk);
      start = 1'b1; rcl = dir; wsel = ws; opnd = x; cin = c; cnt_in = cn;
      @(negedge clk);
      start = 1'b0;
      n = 1;
      while (!done && n < 200) begin
         @(negedge clk);
         n++;
      end
      if (cm == 0)              tg = "R4";
      else if (cn[7:5] != 3'd0) tg = "R1/R2";
      else                      tg = "R1";
      chk($sformatf("%s result dir=%0d w=%0d cnt=%0d", tg, dir, w, cm), res, ex);
      chk($sformatf("%s R3 carry dir=%0d w=%0d cnt=%0d", tg, dir, w, cm), 32'(cout), 32'(ec));
      if (cm > w) chk($sformatf("R6 latency w=%0d cnt=%0d", w, cm), 32'(n), 32'(LAT + k + 1));
      else        chk($sformatf("R5 latency w=%0d cnt=%0d", w, cm), 32'(n), 32'(LAT + 1));
      if (w < 32) chk("R9 upper bits", res >> w, 32'h0);
      @(negedge clk);
      chk("R8 done pulse", 32'(done), 32'h0);
      chk("R8 hold result", res, ex);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] pats [6];
      int n;
      pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h8000_0001;
      pats[3] = 32'h1234_5678; pats[4] = 32'hA5C3_0F96; pats[5] = 32'h7FFF_FFFE;

      repeat (2) @(negedge clk);
      chk("R10 busy in reset", 32'(busy), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 busy", 32'(busy), 32'h0);
      chk("R10 done", 32'(done), 32'h0);
      chk("R10 res", res, 32'h0);
      chk("R10 cout", 32'(cout), 32'h0);

      // Byte right rotate of 0x0A, carry 1, count 0x73 -> masked 19.
      run_op(1'b0, 2'b00, 32'h0000_000A, 1'b1, 8'h73);
      chk("R1 worked example", res, 32'h0000_0085);

      // Byte width: near-exhaustive sweep.
      for (int i = 0; i < 16; i++) begin
         for (int d = 0; d < 2; d++) begin
            for (int cf = 0; cf < 2; cf++) begin
               for (int c = 0; c < 32; c++) begin
                  run_op(d[0], 2'b00, 32'hDEAD_0000 | 32'(i * 17),
                         cf[0], {3'(i + c), 5'(c)});
               end
            end
         end
      end

      // Halfword and word widths.
      for (int p = 0; p < 6; p++) begin
         for (int d = 0; d < 2; d++) begin
            for (int cf = 0; cf < 2; cf++) begin
               for (int c = 0; c < 32; c++) begin
                  run_op(d[0], 2'b01, pats[p], cf[0], {3'(p), 5'(c)});
                  run_op(d[0], p[0] ? 2'b11 : 2'b10, pats[p] ^ 32'(c * 3),
                         cf[0], {3'(c), 5'(c)});
               end
            end
         end
      end

      // R7: start while busy and during the done cycle is ignored.
      @(negedge clk);
      start = 1'b1; rcl = 1'b0; wsel = 2'b00; opnd = 32'h0A; cin = 1'b1; cnt_in = 8'h73;
      @(negedge clk);
      start = 1'b0;
      n = 1;
      @(negedge clk); n++;
      @(negedge clk); n++;
      start = 1'b1; rcl = 1'b1; wsel = 2'b10; opnd = 32'hFFFF_0000; cin = 1'b0; cnt_in = 8'd5;
      @(negedge clk); n++;
      start = 1'b0;
      while (!done && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk("R7 latency unchanged by busy start", 32'(n), 32'(LAT + 2 + 1));
      chk("R7 result of first request", res, 32'h0000_0085);
      chk("R7 carry of first request", 32'(cout), 32'h0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R7 start in done cycle not accepted", 32'(busy), 32'h0);
      chk("R7 result kept", res, 32'h0000_0085);
      @(negedge clk);
      chk("R7 still idle", 32'(busy), 32'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule